// File: doc/BRIEF.md
# Snoop Response Combiner

This block sits at the far end of a coherent on-chip response bus. Each bus transaction, identified by a tag, is placed on the snoop bus. Each attached snooper returns a 3-bit verdict a fixed number of cycles later. A snooper is a cache that reports its hit state or a retry, or a memory controller that claims the address range. All snoopers answer in the same cycle, so the block needs no tag on the local answers. It finds the pending transaction they belong to by delaying the snoop's table slot by that fixed latency.

A neighbouring fabric can be attached through a separate port. That port delivers one already-merged remote verdict per tag, and the verdict may arrive late. While that port is enabled, a transaction is not finished until its remote verdict is in. The remote verdict then competes with the local ones under the same priority rules. The block keeps up to a parameterised number of transactions in flight. It issues exactly one combined result per transaction, in the order the snoops were accepted. The result says whether the transaction must be retried, whether the address hit no owner, which unit must supply the data, and whether the other holders must invalidate or fall back to shared.

Top module: `snoop_combiner`

## Requirements
- R1: A snoop accepted at clock edge E has its local verdicts sampled from `snp_rsp` at edge E+SNP_LAT. When no remote fabric is attached, `cr_valid` is high for exactly one cycle, after edge E+SNP_LAT+1.
- R2: Verdict codes are 0 none, 1 address claim, 2 shared copy, 3 shared copy able to supply, 4 modified copy, 5 retry. Codes 6 and 7 count as none. Snooper i uses bits [3i+2:3i] of `snp_rsp`. The highest code decides the outcome.
- R3: If any local or remote verdict is retry, `cr_status` is 1 and the source, invalidate and share outputs are all low.
- R4: A read (`snp_op` 0, with 3 handled the same way) whose highest code is 3 or 4 takes its data from the lowest-numbered snooper reporting that code, and sets `cr_share`.
- R5: A read without such a holder takes its data from the lowest-numbered claiming snooper. `cr_share` is set only if a shared copy (code 2) was reported.
- R6: A read-for-ownership (`snp_op` 1) chooses its source as a read does, sets `cr_invalidate`, and leaves `cr_share` low.
- R7: An invalidate (`snp_op` 2) that finds a copy or a claimer reports status 0 with `cr_invalidate` set and no data source.
- R8: Status is 2 (address error) with no actions when a read or read-for-ownership has neither a supplying holder nor a claimer, or when an invalidate finds neither a copy nor a claimer.
- R9: While `remote_attached` is high, a transaction completes one cycle after the later of its local sampling and its tag-matched remote verdict. The remote verdict wins only when it is strictly higher than the local best. It then names source `NUM_SNP`. A remote claim is used only when no local unit claims.
- R10: While `remote_attached` is low, the remote inputs have no effect on results or timing.
- R11: Up to DEPTH transactions are outstanding. Results leave in snoop order. `table_full` is high while DEPTH are pending, and a snoop offered then is dropped and never answered.
- R12: After reset, `cr_valid` and `table_full` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| remote_attached | input | 1 | A neighbouring fabric contributes a remote verdict |
| snp_valid | input | 1 | Snoop issued this cycle |
| snp_tag | input | TAG_W | Transaction tag |
| snp_op | input | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 read |
| snp_rsp | input | 3*NUM_SNP | Local verdicts, sampled SNP_LAT edges after the snoop |
| rmt_valid | input | 1 | Remote merged verdict present |
| rmt_tag | input | TAG_W | Tag of the remote verdict |
| rmt_code | input | 3 | Remote verdict code |
| table_full | output | 1 | DEPTH transactions pending |
| cr_valid | output | 1 | Combined result present |
| cr_tag | output | TAG_W | Tag of the result |
| cr_status | output | 2 | 0 done, 1 retry, 2 address error |
| cr_src_valid | output | 1 | A data source is named |
| cr_src_id | output | $clog2(NUM_SNP+1) | Supplying snooper; NUM_SNP means the remote fabric |
| cr_invalidate | output | 1 | Other holders go invalid |
| cr_share | output | 1 | Holders end in shared state |

## Verification
A single snoop's local verdicts must be driven in the cycle that ends at edge E+3 (SNP_LAT is 3). Its result is then due in the cycle after edge E+4. The bench checks that `cr_valid` is still low one cycle earlier and low again one cycle later. With a remote verdict delayed by d cycles, everything shifts by d. In the burst test, snoop i is answered at E+i+3 and read back after E+i+4. In the out-of-order remote test, the younger transaction's result waits one cycle behind the older one. All inputs are driven and all outputs sampled on falling edges, so every expected cycle is a fixed count of rising edges from the stimulus.

// File: rtl/scomb_pkg.sv
package scomb_pkg;

    typedef enum logic [2:0] {
        RSP_NONE    = 3'd0,
        RSP_CLAIM   = 3'd1,
        RSP_SHARED  = 3'd2,
        RSP_SH_INT  = 3'd3,
        RSP_MOD_INT = 3'd4,
        RSP_RETRY   = 3'd5
    } rsp_e;

    typedef enum logic [1:0] {
        OP_READ     = 2'd0,
        OP_RFO      = 2'd1,
        OP_KILL     = 2'd2,
        OP_READ_ALT = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        CR_DONE     = 2'd0,
        CR_RETRY    = 2'd1,
        CR_ADDR_ERR = 2'd2
    } cr_e;

    // Unused code points collapse to "no response".
    function automatic logic [2:0] rsp_norm(input logic [2:0] c);
        return (c > 3'd5) ? 3'd0 : c;
    endfunction

    // A verdict that makes the responder a data supplier.
    function automatic logic is_holder(input logic [2:0] c);
        return (c == RSP_SH_INT) || (c == RSP_MOD_INT);
    endfunction

endpackage

// File: rtl/scomb_merge.sv
module scomb_merge
    import scomb_pkg::*;
#(
    parameter int NUM_SNP = 4,
    parameter int ID_W    = 3
) (
    input  logic [NUM_SNP*3-1:0] rsp_in,
    output logic [2:0]           best_o,
    output logic [ID_W-1:0]      hold_o,
    output logic                 claim_v_o,
    output logic [ID_W-1:0]      claim_o
);

    logic [2:0] code [NUM_SNP];

    genvar g;
    generate
        for (g = 0; g < NUM_SNP; g++) begin : g_norm
            assign code[g] = rsp_norm(rsp_in[g*3 +: 3]);
        end
    endgenerate

    always_comb begin
        best_o    = '0;
        hold_o    = '0;
        claim_v_o = 1'b0;
        claim_o   = '0;
        for (int i = 0; i < NUM_SNP; i++) begin
            if (code[i] > best_o) best_o = code[i];
        end
        // Walk downward so the lowest index is the one left standing.
        for (int i = NUM_SNP - 1; i >= 0; i--) begin
            if (code[i] == best_o && is_holder(code[i])) hold_o = ID_W'(i);
            if (code[i] == RSP_CLAIM) begin
                claim_v_o = 1'b1;
                claim_o   = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/scomb_delay.sv
module scomb_delay #(
    parameter int LAT   = 3,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [IDX_W-1:0] in_idx,
    output logic             out_vld,
    output logic [IDX_W-1:0] out_idx
);

    typedef struct packed {
        logic [LAT-1:0]            vld;
        logic [LAT-1:0][IDX_W-1:0] idx;
    } pipe_t;

    pipe_t p_q, p_d;

    always_comb begin
        p_d        = p_q;
        p_d.vld[0] = in_vld;
        p_d.idx[0] = in_idx;
        for (int s = 1; s < LAT; s++) begin
            p_d.vld[s] = p_q.vld[s-1];
            p_d.idx[s] = p_q.idx[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign out_vld = p_q.vld[LAT-1];
    assign out_idx = p_q.idx[LAT-1];

endmodule

// File: rtl/scomb_decide.sv
module scomb_decide
    import scomb_pkg::*;
#(
    parameter int NUM_SNP = 4,
    parameter int ID_W    = 3
) (
    input  logic [1:0]      op,
    input  logic [2:0]      l_best,
    input  logic [ID_W-1:0] l_hold,
    input  logic            l_clm_v,
    input  logic [ID_W-1:0] l_clm,
    input  logic            r_use,
    input  logic [2:0]      r_code,
    output logic [1:0]      status,
    output logic            src_v,
    output logic [ID_W-1:0] src_id,
    output logic            inv,
    output logic            shr
);

    logic [2:0]      eff_best;
    logic [2:0]      rc;
    logic [ID_W-1:0] hold;
    logic            clm_v;
    logic [ID_W-1:0] clm;

    always_comb begin
        rc       = rsp_norm(r_code);
        eff_best = l_best;
        hold     = l_hold;
        clm_v    = l_clm_v;
        clm      = l_clm;
        if (r_use) begin
            // Ties keep the local responder.
            if (rc > l_best) begin
                eff_best = rc;
                if (is_holder(rc)) hold = ID_W'(NUM_SNP);
            end
            if (!l_clm_v && rc == RSP_CLAIM) begin
                clm_v = 1'b1;
                clm   = ID_W'(NUM_SNP);
            end
        end

        status = CR_DONE;
        src_v  = 1'b0;
        src_id = '0;
        inv    = 1'b0;
        shr    = 1'b0;
        if (eff_best == RSP_RETRY) begin
            status = CR_RETRY;
        end else if (op == OP_KILL) begin
            if (eff_best == RSP_NONE && !clm_v) status = CR_ADDR_ERR;
            else                                inv    = 1'b1;
        end else begin
            if (is_holder(eff_best)) begin
                src_v  = 1'b1;
                src_id = hold;
            end else if (clm_v) begin
                src_v  = 1'b1;
                src_id = clm;
            end else begin
                status = CR_ADDR_ERR;
            end
            if (src_v) begin
                if (op == OP_RFO) inv = 1'b1;
                else              shr = (eff_best >= RSP_SHARED);
            end
        end
    end

endmodule

// File: rtl/snoop_combiner.sv
module snoop_combiner
    import scomb_pkg::*;
#(
    parameter int NUM_SNP = 4,
    parameter int TAG_W   = 4,
    parameter int DEPTH   = 4,
    parameter int SNP_LAT = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             remote_attached,
    input  logic                             snp_valid,
    input  logic [TAG_W-1:0]                 snp_tag,
    input  logic [1:0]                       snp_op,
    input  logic [NUM_SNP*3-1:0]             snp_rsp,
    input  logic                             rmt_valid,
    input  logic [TAG_W-1:0]                 rmt_tag,
    input  logic [2:0]                       rmt_code,
    output logic                             table_full,
    output logic                             cr_valid,
    output logic [TAG_W-1:0]                 cr_tag,
    output logic [1:0]                       cr_status,
    output logic                             cr_src_valid,
    output logic [$clog2(NUM_SNP+1)-1:0]     cr_src_id,
    output logic                             cr_invalidate,
    output logic                             cr_share
);

    localparam int ID_W  = $clog2(NUM_SNP + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [1:0]       op;
        logic             loc_done;
        logic [2:0]       best;
        logic [ID_W-1:0]  hold;
        logic             clm_v;
        logic [ID_W-1:0]  clm;
        logic             rmt_done;
        logic [2:0]       rcode;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic             cr_v;
        logic [TAG_W-1:0] cr_tag;
        logic [1:0]       cr_st;
        logic             cr_srcv;
        logic [ID_W-1:0]  cr_src;
        logic             cr_inv;
        logic             cr_shr;
    } st_t;

    st_t s_q, s_d;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Snoop acceptance and the fixed-latency slot return
    logic             accept;
    logic             pipe_vld;
    logic [PTR_W-1:0] pipe_idx;

    assign table_full = (s_q.cnt == CNT_W'(DEPTH));
    assign accept     = snp_valid && !table_full;

    scomb_delay #(.LAT(SNP_LAT), .IDX_W(PTR_W)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (accept),
        .in_idx  (s_q.wr),
        .out_vld (pipe_vld),
        .out_idx (pipe_idx)
    );

    // Local verdict reduction
    logic [2:0]      m_best;
    logic [ID_W-1:0] m_hold;
    logic            m_clm_v;
    logic [ID_W-1:0] m_clm;

    scomb_merge #(.NUM_SNP(NUM_SNP), .ID_W(ID_W)) u_merge (
        .rsp_in    (snp_rsp),
        .best_o    (m_best),
        .hold_o    (m_hold),
        .claim_v_o (m_clm_v),
        .claim_o   (m_clm)
    );

    // Remote verdict lookup by tag, oldest pending entry first
    logic             rmt_hit;
    logic [PTR_W-1:0] rmt_idx;
    logic [PTR_W-1:0] j;

    always_comb begin
        rmt_hit = 1'b0;
        rmt_idx = '0;
        j       = '0;
        if (remote_attached && rmt_valid) begin
            for (int k = 0; k < DEPTH; k++) begin
                j = PTR_W'((int'(s_q.rd) + k) % DEPTH);
                if (!rmt_hit && s_q.ent[j].vld && !s_q.ent[j].rmt_done &&
                    s_q.ent[j].tag == rmt_tag) begin
                    rmt_hit = 1'b1;
                    rmt_idx = j;
                end
            end
        end
    end

    // Head-of-table decision
    ent_t            head;
    logic            head_ready;
    logic [1:0]      d_status;
    logic            d_srcv;
    logic [ID_W-1:0] d_src;
    logic            d_inv;
    logic            d_shr;

    assign head       = s_q.ent[s_q.rd];
    assign head_ready = head.vld && head.loc_done && (head.rmt_done || !remote_attached);

    scomb_decide #(.NUM_SNP(NUM_SNP), .ID_W(ID_W)) u_decide (
        .op      (head.op),
        .l_best  (head.best),
        .l_hold  (head.hold),
        .l_clm_v (head.clm_v),
        .l_clm   (head.clm),
        .r_use   (remote_attached && head.rmt_done),
        .r_code  (head.rcode),
        .status  (d_status),
        .src_v   (d_srcv),
        .src_id  (d_src),
        .inv     (d_inv),
        .shr     (d_shr)
    );

    // Next-state computation
    ent_t new_ent;

    always_comb begin
        s_d      = s_q;
        s_d.cr_v = 1'b0;

        new_ent     = '0;
        new_ent.vld = 1'b1;
        new_ent.tag = snp_tag;
        new_ent.op  = snp_op;

        if (pipe_vld) begin
            s_d.ent[pipe_idx].loc_done = 1'b1;
            s_d.ent[pipe_idx].best     = m_best;
            s_d.ent[pipe_idx].hold     = m_hold;
            s_d.ent[pipe_idx].clm_v    = m_clm_v;
            s_d.ent[pipe_idx].clm      = m_clm;
        end

        if (rmt_hit) begin
            s_d.ent[rmt_idx].rmt_done = 1'b1;
            s_d.ent[rmt_idx].rcode    = rmt_code;
        end

        if (head_ready) begin
            s_d.cr_v    = 1'b1;
            s_d.cr_tag  = head.tag;
            s_d.cr_st   = d_status;
            s_d.cr_srcv = d_srcv;
            s_d.cr_src  = d_src;
            s_d.cr_inv  = d_inv;
            s_d.cr_shr  = d_shr;
            s_d.ent[s_q.rd].vld      = 1'b0;
            s_d.ent[s_q.rd].loc_done = 1'b0;
            s_d.ent[s_q.rd].rmt_done = 1'b0;
            s_d.rd = ptr_inc(s_q.rd);
        end

        if (accept) begin
            s_d.ent[s_q.wr] = new_ent;
            s_d.wr          = ptr_inc(s_q.wr);
        end

        s_d.cnt = s_q.cnt + CNT_W'(accept) - CNT_W'(head_ready);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cr_valid      = s_q.cr_v;
    assign cr_tag        = s_q.cr_tag;
    assign cr_status     = s_q.cr_st;
    assign cr_src_valid  = s_q.cr_srcv;
    assign cr_src_id     = s_q.cr_src;
    assign cr_invalidate = s_q.cr_inv;
    assign cr_share      = s_q.cr_shr;

    // Checks
    AST_LOCAL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_vld |-> (s_q.ent[pipe_idx].vld && !s_q.ent[pipe_idx].loc_done)); // R1

    AST_RETRY_NO_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_valid && cr_status == CR_RETRY) |-> (!cr_src_valid && !cr_invalidate && !cr_share)); // R3

    AST_ERR_NO_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_valid && cr_status == CR_ADDR_ERR) |-> (!cr_src_valid && !cr_invalidate && !cr_share)); // R8

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH)); // R11

    AST_FULL_HOLDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        table_full |=> $stable(s_q.wr)); // R11

endmodule

// File: tb/snoop_combiner_tb.sv
module snoop_combiner_tb;
    import scomb_pkg::*;

    localparam int NS  = 4;
    localparam int TW  = 4;
    localparam int IDW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic            remote_attached = 1'b0;
    logic            snp_valid = 1'b0;
    logic [TW-1:0]   snp_tag = '0;
    logic [1:0]      snp_op = '0;
    logic [NS*3-1:0] snp_rsp = '0;
    logic            rmt_valid = 1'b0;
    logic [TW-1:0]   rmt_tag = '0;
    logic [2:0]      rmt_code = '0;
    logic            table_full, cr_valid, cr_src_valid, cr_invalidate, cr_share;
    logic [TW-1:0]   cr_tag;
    logic [1:0]      cr_status;
    logic [IDW-1:0]  cr_src_id;

    snoop_combiner #(.NUM_SNP(NS), .TAG_W(TW), .DEPTH(4), .SNP_LAT(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .remote_attached(remote_attached),
        .snp_valid(snp_valid), .snp_tag(snp_tag), .snp_op(snp_op), .snp_rsp(snp_rsp),
        .rmt_valid(rmt_valid), .rmt_tag(rmt_tag), .rmt_code(rmt_code),
        .table_full(table_full), .cr_valid(cr_valid), .cr_tag(cr_tag),
        .cr_status(cr_status), .cr_src_valid(cr_src_valid), .cr_src_id(cr_src_id),
        .cr_invalidate(cr_invalidate), .cr_share(cr_share)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] rsp;    // {s3,s2,s1,s0}
        logic        ren;
        logic [2:0]  rcode;
        logic [1:0]  rdly;
        logic [1:0]  st;
        logic        srcv;
        logic [2:0]  src;
        logic        inv;
        logic        shr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{2'd0, {3'd0,3'd1,3'd0,3'd0}, 1'b0, 3'd0, 2'd0, 2'd0, 1'b1, 3'd2, 1'b0, 1'b0, 4'd5}, // R5 claim only
        '{2'd0, {3'd2,3'd0,3'd4,3'd1}, 1'b0, 3'd0, 2'd0, 2'd0, 1'b1, 3'd1, 1'b0, 1'b1, 4'd4}, // R4 R2 modified wins
        '{2'd0, {3'd1,3'd3,3'd0,3'd3}, 1'b0, 3'd0, 2'd0, 2'd0, 1'b1, 3'd0, 1'b0, 1'b1, 4'd4}, // R4 lowest holder
        '{2'd0, {3'd1,3'd0,3'd2,3'd0}, 1'b0, 3'd0, 2'd0, 2'd0, 1'b1, 3'd3, 1'b0, 1'b1, 4'd5}, // R5 shared + claim
        '{2'd0, {3'd0,3'd5,3'd0,3'd4}, 1'b0, 3'd0, 2'd0, 2'd1, 1'b0, 3'd0, 1'b0, 1'b0, 4'd3}, // R3 local retry
        '{2'd1, {3'd4,3'd0,3'd0,3'd1}, 1'b0, 3'd0, 2'd0, 2'd0, 1'b1, 3'd3, 1'b1, 1'b0, 4'd6}, // R6 rfo modified
        '{2'd1, {3'd0,3'd0,3'd1,3'd0}, 1'b0, 3'd0, 2'd0, 2'd0, 1'b1, 3'd1, 1'b1, 1'b0, 4'd6}, // R6 rfo memory
        '{2'd2, {3'd0,3'd2,3'd1,3'd2}, 1'b0, 3'd0, 2'd0, 2'd0, 1'b0, 3'd0, 1'b1, 1'b0, 4'd7}, // R7 invalidate
        '{2'd0, {3'd0,3'd0,3'd0,3'd0}, 1'b0, 3'd0, 2'd0, 2'd2, 1'b0, 3'd0, 1'b0, 1'b0, 4'd8}, // R8 nobody
        '{2'd0, {3'd0,3'd0,3'd0,3'd2}, 1'b0, 3'd0, 2'd0, 2'd2, 1'b0, 3'd0, 1'b0, 1'b0, 4'd8}, // R8 shared no claim
        '{2'd2, {3'd0,3'd0,3'd0,3'd0}, 1'b0, 3'd0, 2'd0, 2'd2, 1'b0, 3'd0, 1'b0, 1'b0, 4'd8}, // R8 invalidate nobody
        '{2'd3, {3'd0,3'd4,3'd0,3'd0}, 1'b0, 3'd0, 2'd0, 2'd0, 1'b1, 3'd2, 1'b0, 1'b1, 4'd4}, // R4 op 3 as read
        '{2'd0, {3'd0,3'd0,3'd7,3'd1}, 1'b0, 3'd0, 2'd0, 2'd0, 1'b1, 3'd0, 1'b0, 1'b0, 4'd2}, // R2 code 7 is none
        '{2'd1, {3'd2,3'd1,3'd0,3'd2}, 1'b0, 3'd0, 2'd0, 2'd0, 1'b1, 3'd2, 1'b1, 1'b0, 4'd6}, // R6 shared copies
        '{2'd0, {3'd0,3'd0,3'd1,3'd0}, 1'b1, 3'd4, 2'd0, 2'd0, 1'b1, 3'd4, 1'b0, 1'b1, 4'd9}, // R9 remote modified
        '{2'd0, {3'd0,3'd3,3'd0,3'd0}, 1'b1, 3'd3, 2'd2, 2'd0, 1'b1, 3'd2, 1'b0, 1'b1, 4'd9}, // R9 tie local wins
        '{2'd0, {3'd0,3'd0,3'd0,3'd4}, 1'b1, 3'd5, 2'd1, 2'd1, 1'b0, 3'd0, 1'b0, 1'b0, 4'd3}, // R3 remote retry
        '{2'd0, {3'd0,3'd0,3'd0,3'd0}, 1'b1, 3'd1, 2'd0, 2'd0, 1'b1, 3'd4, 1'b0, 1'b0, 4'd9}, // R9 remote claim
        '{2'd0, {3'd1,3'd0,3'd0,3'd0}, 1'b1, 3'd2, 2'd0, 2'd0, 1'b1, 3'd3, 1'b0, 1'b1, 4'd9}  // R9 local claim kept
    };

    task automatic run_vec(input vec_t v, input logic [TW-1:0] tg);
        string rq;
        int    fin;
        rq  = $sformatf("R%0d", v.req);
        fin = 5 + (v.ren ? int'(v.rdly) : 0);
        remote_attached = v.ren;
        @(negedge clk);
        snp_valid = 1'b1;
        snp_tag   = tg;
        snp_op    = v.op;
        for (int m = 1; m <= fin; m++) begin
            @(negedge clk);
            if (m == fin - 1) chk("R1", "cr_valid before due", int'(cr_valid), 0);
            if (m == fin) begin
                chk(rq, "cr_valid", int'(cr_valid), 1);
                chk(rq, "cr_tag", int'(cr_tag), int'(tg));
                chk(rq, "cr_status", int'(cr_status), int'(v.st));
                chk(rq, "cr_src_valid", int'(cr_src_valid), int'(v.srcv));
                if (v.srcv) chk(rq, "cr_src_id", int'(cr_src_id), int'(v.src));
                chk(rq, "cr_invalidate", int'(cr_invalidate), int'(v.inv));
                chk(rq, "cr_share", int'(cr_share), int'(v.shr));
            end
            snp_valid = 1'b0;
            snp_rsp   = (m == 3) ? v.rsp : '0;
            rmt_valid = v.ren && (m == 3 + int'(v.rdly));
            rmt_tag   = tg;
            rmt_code  = v.rcode;
        end
        @(negedge clk);
        chk("R1", "cr_valid single pulse", int'(cr_valid), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        chk("R12", "cr_valid in reset", int'(cr_valid), 0);
        chk("R12", "table_full in reset", int'(table_full), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "cr_valid after reset", int'(cr_valid), 0);
        chk("R12", "table_full after reset", int'(table_full), 0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], TW'(i + 1));

        // R10: remote retry while detached must be ignored
        remote_attached = 1'b0;
        @(negedge clk);
        snp_valid = 1'b1; snp_tag = 4'd9; snp_op = OP_READ;
        for (int m = 1; m <= 5; m++) begin
            @(negedge clk);
            if (m == 5) begin
                chk("R10", "cr_valid", int'(cr_valid), 1);
                chk("R10", "cr_status", int'(cr_status), 0);
                chk("R10", "cr_src_id", int'(cr_src_id), 0);
            end
            snp_valid = 1'b0;
            snp_rsp   = (m == 3) ? {3'd0, 3'd0, 3'd0, 3'd4} : '0;
            rmt_valid = (m == 3);
            rmt_tag   = 4'd9;
            rmt_code  = 3'd5;
        end
        rmt_valid = 1'b0;

        // R11: four back-to-back snoops, a fifth dropped while full
        for (int m = 0; m <= 14; m++) begin
            @(negedge clk);
            if (m == 4) chk("R11", "table_full", int'(table_full), 1);
            if (m >= 5 && m <= 8) begin
                chk("R11", "cr_valid burst", int'(cr_valid), 1);
                chk("R11", "cr_tag order", int'(cr_tag), m - 4);
                chk("R11", "cr_src_id", int'(cr_src_id), m - 5);
            end else if (m >= 9) begin
                chk("R11", "dropped snoop answered", int'(cr_valid), 0);
            end
            snp_valid = (m <= 4);
            snp_tag   = TW'(m + 1);
            snp_op    = OP_READ;
            case (m)
                3:       snp_rsp = {3'd0, 3'd0, 3'd0, 3'd1};
                4:       snp_rsp = {3'd0, 3'd0, 3'd4, 3'd0};
                5:       snp_rsp = {3'd0, 3'd3, 3'd0, 3'd0};
                6:       snp_rsp = {3'd1, 3'd0, 3'd0, 3'd0};
                default: snp_rsp = '0;
            endcase
        end

        // R9: remote verdicts arrive out of order, results stay in order
        remote_attached = 1'b1;
        for (int m = 0; m <= 11; m++) begin
            @(negedge clk);
            if (m >= 5 && m <= 8) chk("R9", "waits for remote", int'(cr_valid), 0);
            if (m == 9) begin
                chk("R9", "older valid", int'(cr_valid), 1);
                chk("R9", "older tag", int'(cr_tag), 6);
                chk("R9", "older src", int'(cr_src_id), 0);
            end
            if (m == 10) begin
                chk("R9", "younger valid", int'(cr_valid), 1);
                chk("R9", "younger tag", int'(cr_tag), 7);
                chk("R9", "younger src", int'(cr_src_id), 1);
            end
            if (m == 11) chk("R9", "no extra result", int'(cr_valid), 0);
            snp_valid = (m <= 1);
            snp_tag   = (m == 0) ? 4'd6 : 4'd7;
            snp_op    = OP_READ;
            snp_rsp   = (m == 3) ? {3'd0, 3'd0, 3'd0, 3'd1} :
                        (m == 4) ? {3'd0, 3'd0, 3'd1, 3'd0} : '0;
            rmt_valid = (m == 5) || (m == 7);
            rmt_tag   = (m == 5) ? 4'd7 : 4'd6;
            rmt_code  = 3'd0;
        end
        rmt_valid = 1'b0;
        remote_attached = 1'b0;

        summary();
        $finish;
    end

endmodule